// File: doc/BRIEF.md
# Line Clamp Pulse Generator

This block produces the gating pulse that tells a video input clamp when to sample the black level, once per line. It runs on one system clock and watches two already-synchronized logic inputs: the horizontal sync signal and the blanking signal. Three configuration fields, held in a control register elsewhere, choose which input starts the pulse, which level of the blanking signal is active, and how many clocks the pulse lasts.

In blanking mode the pulse starts on the leading edge of the blanking interval. In sync mode it starts on the end of the sync pulse. Sync can be positive-going or negative-going. The block measures the high and low phases of the sync signal and treats the shorter one as the sync pulse, so it always fires on the true trailing edge. A trigger that arrives while a pulse is running is dropped. The width is sampled when a pulse starts.

Top module: `cpg_clamp_gen`

## Requirements
- R1: While reset is held and on the first clock after it, `clamp_o` is 0. Until the first polarity decision, sync is taken as active-high.
- R2: With `cfg_src_blank_i`=1 and `cfg_blank_low_i`=0, a 0-to-1 change on `blank_i` starts a pulse. `clamp_o` rises at the clock edge where the new level is first sampled.
- R3: With `cfg_src_blank_i`=1 and `cfg_blank_low_i`=1, a 1-to-0 change on `blank_i` starts a pulse, and a 0-to-1 change does not.
- R4: With `cfg_src_blank_i`=0, the trailing edge of sync starts a pulse. That is a 1-to-0 change on `hsync_i` while sync is judged active-high, and a 0-to-1 change while it is judged active-low.
- R5: The polarity decision is made on each 0-to-1 change of `hsync_i`, once a complete high phase has been measured. Sync becomes active-low if the low phase that just ended is strictly shorter than the last complete high phase; otherwise it is active-high. Phase lengths saturate at 2^RUN_W-1 clocks.
- R6: `cfg_width_i` codes 0, 1, 2 and 3 give pulses of 16, 32, 48 and 64 clocks.
- R7: A trigger edge seen while `clamp_o` is 1 is ignored and does not lengthen the pulse.
- R8: A change of `cfg_width_i` during a pulse leaves that pulse's length unchanged and applies from the next pulse.
- R9: Changing `cfg_src_blank_i` or `cfg_blank_low_i` never starts a pulse by itself. Edges on the source that is not selected start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_i | input | 1 | Synchronized horizontal sync |
| blank_i | input | 1 | Synchronized blanking signal |
| cfg_src_blank_i | input | 1 | 1: trigger on blanking leading edge; 0: trigger on sync trailing edge |
| cfg_blank_low_i | input | 1 | 1: blanking is active-low; 0: active-high |
| cfg_width_i | input | 2 | Pulse width code |
| clamp_o | output | 1 | Clamp gating pulse, registered |

## Verification
The bench first feeds positive sync lines and then switches to negative sync mid-run. The changeover line is where a wrong polarity comparison would fire on the leading edge of sync, or fire twice per line. Short blanking glitches arrive inside a running pulse; a design that retriggers would stretch the pulse past its width. The width code is changed halfway through a pulse; a design that does not sample the width at the start would cut the pulse short or extend it. Configuration bits are flipped while both inputs are steady, and the unselected input is toggled, to catch designs that create edges from mode changes.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

  typedef enum logic {
    SRC_HSYNC = 1'b0,
    SRC_BLANK = 1'b1
  } cpg_src_e;

  function automatic int unsigned width_cycles(input logic [1:0] code,
                                               input int unsigned base);
    return base * (int'(code) + 1);
  endfunction

endpackage

// File: rtl/cpg_edge_det.sv
module cpg_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);

  logic sig_q;

  always_ff @(posedge clk) begin
    sig_q <= sig_i;
  end

  assign rise_o = !rst && sig_i && !sig_q;
  assign fall_o = !rst && !sig_i && sig_q;

endmodule

// File: rtl/cpg_hs_polarity.sv
module cpg_hs_polarity #(
  parameter int RUN_W = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  input  logic fall_i,
  output logic active_low_o
);

  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] high_len_q;
  logic             seen_rise_q;
  logic             have_high_q;
  logic             pol_low_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q       <= '0;
      high_len_q  <= '0;
      seen_rise_q <= 1'b0;
      have_high_q <= 1'b0;
      pol_low_q   <= 1'b0;
    end else begin
      if (rise_i || fall_i)
        run_q <= RUN_W'(1);
      else if (run_q != RUN_MAX)
        run_q <= run_q + 1'b1;

      if (rise_i) begin
        seen_rise_q <= 1'b1;
        if (have_high_q)
          pol_low_q <= (run_q < high_len_q);
      end

      if (fall_i && seen_rise_q) begin
        high_len_q  <= run_q;
        have_high_q <= 1'b1;
      end
    end
  end

  assign active_low_o = pol_low_q;

  // R5: the polarity decision moves only on a rising sync edge
  a_r5_update_on_rise: assert property (@(posedge clk) disable iff (rst)
    (pol_low_q != $past(pol_low_q)) |-> $past(rise_i));

endmodule

// File: rtl/cpg_pulse_timer.sv
module cpg_pulse_timer #(
  parameter int BASE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       trig_i,
  input  logic [1:0] width_i,
  output logic       pulse_o
);
  import cpg_pkg::*;

  localparam int MAX_W = 4 * BASE;
  localparam int CNT_W = $clog2(MAX_W);

  logic [CNT_W-1:0] rem_q;
  logic             pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      rem_q   <= '0;
    end else if (pulse_q) begin
      if (rem_q == '0)
        pulse_q <= 1'b0;
      else
        rem_q <= rem_q - 1'b1;
    end else if (trig_i) begin
      pulse_q <= 1'b1;
      rem_q   <= CNT_W'(width_cycles(width_i, BASE) - 1);
    end
  end

  assign pulse_o = pulse_q;

  // checker state: length of the running pulse and width sampled at its start
  logic [CNT_W:0] chk_len;
  logic [CNT_W:0] chk_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_len <= '0;
      chk_w   <= '0;
    end else begin
      chk_len <= pulse_q ? chk_len + 1'b1 : '0;
      if (!pulse_q && trig_i)
        chk_w <= (CNT_W+1)'(width_cycles(width_i, BASE));
    end
  end

  // R6, R8: every finished pulse lasted the width sampled at its start
  a_r6_width: assert property (@(posedge clk) disable iff (rst)
    (!pulse_q && $past(pulse_q)) |-> (chk_len == chk_w));

  // R7: nothing starts a pulse except a trigger while idle
  a_r7_no_spont: assert property (@(posedge clk) disable iff (rst)
    (!pulse_q && !trig_i) |=> !pulse_q);

  // R1: output is low right after a reset cycle
  a_r1_reset_low: assert property (@(posedge clk)
    $past(rst) |-> !pulse_q);

endmodule

// File: rtl/cpg_clamp_gen.sv
module cpg_clamp_gen #(
  parameter int BASE  = 16,
  parameter int RUN_W = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hsync_i,
  input  logic       blank_i,
  input  logic       cfg_src_blank_i,
  input  logic       cfg_blank_low_i,
  input  logic [1:0] cfg_width_i,
  output logic       clamp_o
);
  import cpg_pkg::*;

  logic hs_rise, hs_fall, bk_rise, bk_fall;
  logic hs_low, hs_trail, bk_lead, trig;
  cpg_src_e src;

  cpg_edge_det u_hs_edge (
    .clk(clk), .rst(rst), .sig_i(hsync_i), .rise_o(hs_rise), .fall_o(hs_fall)
  );

  cpg_edge_det u_bk_edge (
    .clk(clk), .rst(rst), .sig_i(blank_i), .rise_o(bk_rise), .fall_o(bk_fall)
  );

  cpg_hs_polarity #(.RUN_W(RUN_W)) u_pol (
    .clk(clk), .rst(rst), .rise_i(hs_rise), .fall_i(hs_fall),
    .active_low_o(hs_low)
  );

  assign src      = cpg_src_e'(cfg_src_blank_i);
  assign hs_trail = hs_low ? hs_rise : hs_fall;
  assign bk_lead  = cfg_blank_low_i ? bk_fall : bk_rise;
  assign trig     = (src == SRC_BLANK) ? bk_lead : hs_trail;

  cpg_pulse_timer #(.BASE(BASE)) u_timer (
    .clk(clk), .rst(rst), .trig_i(trig), .width_i(cfg_width_i),
    .pulse_o(clamp_o)
  );

  // R2: an active-high blanking leading edge while idle starts a pulse
  a_r2_blank_start: assert property (@(posedge clk) disable iff (rst)
    (cfg_src_blank_i && !cfg_blank_low_i && bk_rise && !clamp_o) |=> clamp_o);

  // R9: in blanking mode sync edges alone start nothing
  a_r9_other_src: assert property (@(posedge clk) disable iff (rst)
    (cfg_src_blank_i && !bk_lead && !clamp_o) |=> !clamp_o);

endmodule

// File: tb/sim_cpg_clamp_gen.sv
module sim_cpg_clamp_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hsync_i = 1'b0;
  logic       blank_i = 1'b0;
  logic       cfg_src_blank_i = 1'b1;
  logic       cfg_blank_low_i = 1'b0;
  logic [1:0] cfg_width_i = 2'd0;
  logic       clamp_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  cpg_clamp_gen u0 (
    .clk(clk), .rst(rst), .hsync_i(hsync_i), .blank_i(blank_i),
    .cfg_src_blank_i(cfg_src_blank_i), .cfg_blank_low_i(cfg_blank_low_i),
    .cfg_width_i(cfg_width_i), .clamp_o(clamp_o)
  );

  // behavioural reference model
  int  m_run, m_high, m_left;
  bit  m_hs, m_bk, m_seen_rise, m_have_high, m_pol_low;

  always @(posedge clk) begin
    if (rst) begin
      m_hs = hsync_i; m_bk = blank_i;
      m_run = 0; m_high = 0; m_left = 0;
      m_seen_rise = 0; m_have_high = 0; m_pol_low = 0;
    end else begin
      bit rh, fh, rb, fb, trig;
      rh = hsync_i && !m_hs;  fh = !hsync_i && m_hs;
      rb = blank_i && !m_bk;  fb = !blank_i && m_bk;
      if (cfg_src_blank_i) trig = cfg_blank_low_i ? fb : rb;
      else                 trig = m_pol_low ? rh : fh;
      if (rh && m_have_high) m_pol_low = (m_run < m_high);
      if (fh && m_seen_rise) begin m_high = m_run; m_have_high = 1; end
      if (rh) m_seen_rise = 1;
      if (rh || fh) m_run = 1;
      else if (m_run < 4095) m_run++;
      if (m_left > 0) m_left--;
      else if (trig) m_left = 16 * (int'(cfg_width_i) + 1);
      m_hs = hsync_i; m_bk = blank_i;
    end
  end

  // per-clock comparison and pulse measurement
  int cur_len = 0, last_len = 0, n_pulses = 0;

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (clamp_o !== (m_left > 0)) begin
        errors++;
        $display("FAIL %s clamp_o=%0b expected=%0b", tag, clamp_o, (m_left > 0));
      end
      if (clamp_o) cur_len++;
      else if (cur_len > 0) begin
        last_len = cur_len; n_pulses++; cur_len = 0;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bk(input logic v, input int n);
    blank_i = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic hs(input logic v, input int n);
    hsync_i = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1", clamp_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", clamp_o, 0);

    // R2 and R6: active-high blanking, every width code
    for (int c = 0; c < 4; c++) begin
      tag = "R6";
      cfg_width_i = 2'(c);
      bk(1'b1, 30);
      bk(1'b0, 80);
      check("R6", last_len, 16 * (c + 1));
    end
    tag = "R2";
    check("R2", n_pulses, 4);

    // R7: glitches inside a running pulse
    tag = "R7";
    cfg_width_i = 2'd1;
    n_pulses = 0;
    bk(1'b1, 3); bk(1'b0, 2); bk(1'b1, 4); bk(1'b0, 3); bk(1'b1, 20);
    bk(1'b0, 60);
    check("R7", n_pulses, 1);
    check("R7", last_len, 32);

    // R8: width change mid-pulse
    tag = "R8";
    cfg_width_i = 2'd3;
    bk(1'b1, 10);
    cfg_width_i = 2'd0;
    bk(1'b1, 20);
    bk(1'b0, 60);
    check("R8", last_len, 64);
    bk(1'b1, 30); bk(1'b0, 10);
    check("R8", last_len, 16);

    // R3 and R9: active-low blanking
    tag = "R9";
    n_pulses = 0;
    cfg_blank_low_i = 1'b1;
    bk(1'b0, 5);
    bk(1'b1, 40);
    check("R9", n_pulses, 0);
    tag = "R3";
    bk(1'b0, 30);
    bk(1'b1, 40);
    check("R3", n_pulses, 1);
    check("R3", last_len, 16);

    // R9: sync mode, blanking toggles, config flips
    tag = "R9";
    n_pulses = 0;
    cfg_src_blank_i = 1'b0;
    bk(1'b0, 10); bk(1'b1, 10);
    cfg_blank_low_i = 1'b0;
    bk(1'b1, 10); bk(1'b0, 30);
    check("R9", n_pulses, 0);

    // R4 and R5: positive sync lines
    tag = "R4";
    n_pulses = 0;
    for (int l = 0; l < 4; l++) begin
      hs(1'b1, 20);
      hs(1'b0, 150);
    end
    check("R4", n_pulses, 4);

    // R5: switch to negative sync
    tag = "R5";
    hs(1'b1, 150);
    for (int l = 0; l < 3; l++) begin
      hs(1'b0, 20);
      hs(1'b1, 150);
    end
    n_pulses = 0;
    for (int l = 0; l < 3; l++) begin
      hs(1'b0, 20);
      hs(1'b1, 150);
    end
    check("R5", n_pulses, 3);

    // R9: back to blanking mode with sync still toggling
    tag = "R9";
    cfg_src_blank_i = 1'b1;
    n_pulses = 0;
    for (int l = 0; l < 2; l++) begin
      hs(1'b0, 20);
      hs(1'b1, 100);
    end
    check("R9", n_pulses, 0);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule